// File: doc/BRIEF.md
# Accumulator Logic and Rotate Unit

This block is a byte-wide execution slice that owns an accumulator and a five-bit status word (sign, zero, auxiliary carry, parity, carry). Each time the issue strobe is high, it applies one operation. The operation can combine the accumulator with an operand byte bitwise, or compare the two. It can also invert the accumulator, adjust the carry, or shift the accumulator by one place. The result and the new flags are captured on that clock edge.

The operand byte is presented directly at the input; the surrounding datapath decides whether it came from a register, memory or an immediate field. A done pulse one cycle after issue tells the sequencer that the accumulator and flags outputs now hold the new state. The flag rules differ for each operation, and the unit enforces them. Bitwise operations recompute sign, zero and parity. Compare touches only flags. Complement of the accumulator touches no flag at all. Rotates change only carry.

Top module: `acc_logic_unit`

## Requirements
- R1: After synchronous reset the accumulator is 00 hex, all five flags are 0 and done is 0.
- R2: Code 0 (AND) writes acc AND operand to the accumulator; sign = result bit 7, zero = 1 when the result is 00, parity = 1 when the result has an even count of ones; carry is cleared and auxiliary carry is forced to 1.
- R3: Code 1 (OR) and code 2 (XOR) write the bitwise result to the accumulator; sign, zero and parity follow the result as in R2, and both carry and auxiliary carry are cleared.
- R4: Code 3 (compare) leaves the accumulator unchanged. Carry = 1 when acc < operand, zero = 1 when they are equal. Sign and parity follow the 8-bit difference acc minus operand. Auxiliary carry = 1 when the low nibble of acc is below the low nibble of the operand.
- R5: Code 4 inverts all eight accumulator bits (AB becomes 54 hex) and leaves every flag unchanged.
- R6: Code 5 inverts carry and code 6 sets carry to 1; neither changes the accumulator or any other flag.
- R7: Code 7 rotates left circularly, and old bit 7 goes to both bit 0 and carry (1F becomes 3E hex). Code 8 rotates right circularly, and old bit 0 goes to both bit 7 and carry. Only carry among the flags changes.
- R8: Code 9 rotates left through carry: old bit 7 goes to carry and old carry goes to bit 0 (0E with carry 1 gives 1D, carry 0). Code 10 rotates right through carry: old bit 0 goes to carry and old carry goes to bit 7 (0E with carry 1 gives 87, carry 0). Only carry changes.
- R9: State changes only on a clock edge where valid is high; done is high for exactly the cycle after each such edge and low otherwise.
- R10: Codes 11 to 15 leave the accumulator and all flags unchanged but still produce a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand byte |
| valid_i | input | 1 | Issue strobe |
| acc_o | output | 8 | Accumulator |
| flag_s_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_ac_o | output | 1 | Auxiliary carry flag |
| flag_p_o | output | 1 | Parity flag (even) |
| flag_cy_o | output | 1 | Carry flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every accumulator value from 00 to FF is paired with four operand patterns for each bitwise and compare code: zero, all ones, a copy of the accumulator, and a scrambled value. These patterns separate the equal, greater and less compare outcomes, the zero and parity corner cases, and nibble-borrow from full borrow. All 256 accumulator values are also rotated in all four directions, once with carry 0 and once with carry 1. This shows whether the old carry enters the vacated bit or does not. Complement, carry operations and the unused codes run against nonzero flag states, so any flag that should be preserved but is disturbed shows up.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int unsigned ACC_W = 8;
    localparam int unsigned NIB_W = 4;
    localparam int unsigned OP_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_CMP  = 4'd3,
        OP_CPLA = 4'd4,
        OP_CPLC = 4'd5,
        OP_SETC = 4'd6,
        OP_ROLC = 4'd7,
        OP_RORC = 4'd8,
        OP_ROLT = 4'd9,
        OP_RORT = 4'd10
    } op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flags_t;

    function automatic logic is_bitwise(op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic is_rotate(op_e op);
        return (op == OP_ROLC) || (op == OP_RORC) ||
               (op == OP_ROLT) || (op == OP_RORT);
    endfunction

endpackage

// File: rtl/acc_status.sv
module acc_status #(
    parameter int unsigned W = acc_pkg::ACC_W
) (
    input  logic [W-1:0] val_i,
    output logic         sgn_o,
    output logic         zero_o,
    output logic         par_o
);
    assign sgn_o  = val_i[W-1];
    assign zero_o = (val_i == '0);
    assign par_o  = ~(^val_i);
endmodule

// File: rtl/acc_bitwise.sv
module acc_bitwise
    import acc_pkg::*;
#(
    parameter int unsigned W   = ACC_W,
    parameter int unsigned NIB = NIB_W
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic [W-1:0] diff_o,
    output logic         borrow_o,
    output logic         nib_borrow_o
);
    logic [W:0] wide;

    always_comb begin
        case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = '0;
        endcase
    end

    assign wide         = {1'b0, a_i} - {1'b0, b_i};
    assign diff_o       = wide[W-1:0];
    assign borrow_o     = wide[W];
    assign nib_borrow_o = (a_i[NIB-1:0] < b_i[NIB-1:0]);
endmodule

// File: rtl/acc_rotate.sv
module acc_rotate
    import acc_pkg::*;
#(
    parameter int unsigned W = ACC_W
) (
    input  op_e          op_i,
    input  logic [W-1:0] a_i,
    input  logic         cy_i,
    output logic [W-1:0] res_o,
    output logic         cy_o
);
    always_comb begin
        case (op_i)
            OP_ROLC: begin
                res_o = {a_i[W-2:0], a_i[W-1]};
                cy_o  = a_i[W-1];
            end
            OP_RORC: begin
                res_o = {a_i[0], a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            OP_ROLT: begin
                res_o = {a_i[W-2:0], cy_i};
                cy_o  = a_i[W-1];
            end
            OP_RORT: begin
                res_o = {cy_i, a_i[W-1:1]};
                cy_o  = a_i[0];
            end
            default: begin
                res_o = a_i;
                cy_o  = cy_i;
            end
        endcase
    end
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
    import acc_pkg::*;
#(
    parameter int unsigned W = ACC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    opnd_i,
    input  logic            valid_i,
    output logic [W-1:0]    acc_o,
    output logic            flag_s_o,
    output logic            flag_z_o,
    output logic            flag_ac_o,
    output logic            flag_p_o,
    output logic            flag_cy_o,
    output logic            done_o
);
    op_e          opc;
    logic [W-1:0] acc_q, acc_d;
    flags_t       fl_q, fl_d;
    logic         done_q;

    logic [W-1:0] bw_res, cmp_diff, rot_res, stat_val;
    logic         cmp_borrow, cmp_nib, rot_cy;
    logic         st_s, st_z, st_p;

    assign opc = op_e'(op_i);

    acc_bitwise #(.W(W)) u_bitwise (
        .op_i         (opc),
        .a_i          (acc_q),
        .b_i          (opnd_i),
        .res_o        (bw_res),
        .diff_o       (cmp_diff),
        .borrow_o     (cmp_borrow),
        .nib_borrow_o (cmp_nib)
    );

    acc_rotate #(.W(W)) u_rotate (
        .op_i  (opc),
        .a_i   (acc_q),
        .cy_i  (fl_q.cy),
        .res_o (rot_res),
        .cy_o  (rot_cy)
    );

    assign stat_val = (opc == OP_CMP) ? cmp_diff : bw_res;

    acc_status #(.W(W)) u_status (
        .val_i  (stat_val),
        .sgn_o  (st_s),
        .zero_o (st_z),
        .par_o  (st_p)
    );

    always_comb begin
        acc_d = acc_q;
        fl_d  = fl_q;
        if (is_bitwise(opc)) begin
            acc_d = bw_res;
            fl_d  = '{s: st_s, z: st_z, ac: (opc == OP_AND), p: st_p, cy: 1'b0};
        end else if (is_rotate(opc)) begin
            acc_d   = rot_res;
            fl_d.cy = rot_cy;
        end else begin
            case (opc)
                OP_CMP:  fl_d = '{s: st_s, z: st_z, ac: cmp_nib, p: st_p, cy: cmp_borrow};
                OP_CPLA: acc_d = ~acc_q;
                OP_CPLC: fl_d.cy = ~fl_q.cy;
                OP_SETC: fl_d.cy = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            fl_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= valid_i;
            if (valid_i) begin
                acc_q <= acc_d;
                fl_q  <= fl_d;
            end
        end
    end

    assign acc_o     = acc_q;
    assign flag_s_o  = fl_q.s;
    assign flag_z_o  = fl_q.z;
    assign flag_ac_o = fl_q.ac;
    assign flag_p_o  = fl_q.p;
    assign flag_cy_o = fl_q.cy;
    assign done_o    = done_q;
endmodule

// File: rtl/acc_logic_unit_chk.sv
module acc_logic_unit_chk
    import acc_pkg::*;
#(
    parameter int unsigned W = ACC_W
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] op_i,
    input logic [W-1:0]    opnd_i,
    input logic            valid_i,
    input logic [W-1:0]    acc_o,
    input logic            flag_s_o,
    input logic            flag_z_o,
    input logic            flag_ac_o,
    input logic            flag_p_o,
    input logic            flag_cy_o,
    input logic            done_o
);
    logic [4:0] fl;
    logic [3:0] fl_nocy;
    assign fl      = {flag_s_o, flag_z_o, flag_ac_o, flag_p_o, flag_cy_o};
    assign fl_nocy = {flag_s_o, flag_z_o, flag_ac_o, flag_p_o};

    a_r2_and_flags: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_AND |=> flag_ac_o && !flag_cy_o);

    a_r3_or_xor_flags: assert property (@(posedge clk) disable iff (rst)
        valid_i && (op_i == OP_OR || op_i == OP_XOR) |=> !flag_ac_o && !flag_cy_o);

    a_r3_and_zero_result: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_OR |=> flag_z_o == (acc_o == '0));

    a_r4_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_CMP |=> $stable(acc_o));

    a_r4_cmp_equal: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_CMP && opnd_i == acc_o |=> flag_z_o && !flag_cy_o);

    a_r5_cpl_acc: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_CPLA |=> acc_o == ~$past(acc_o) && $stable(fl));

    a_r6_set_carry: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_SETC |=> flag_cy_o && $stable(fl_nocy) && $stable(acc_o));

    a_r6_cpl_carry: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_CPLC |=> flag_cy_o != $past(flag_cy_o) && $stable(fl_nocy));

    a_r7_rol_circ: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_ROLC |=>
            acc_o == {$past(acc_o[W-2:0]), $past(acc_o[W-1])} &&
            flag_cy_o == $past(acc_o[W-1]) && $stable(fl_nocy));

    a_r8_ror_thru: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i == OP_RORT |=>
            acc_o == {$past(flag_cy_o), $past(acc_o[W-1:1])} &&
            flag_cy_o == $past(acc_o[0]));

    a_r9_done_after_issue: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> done_o);

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !done_o && $stable(acc_o) && $stable(fl));

    a_r10_unused_code: assert property (@(posedge clk) disable iff (rst)
        valid_i && op_i > OP_RORT |=> $stable(acc_o) && $stable(fl));
endmodule

bind acc_logic_unit acc_logic_unit_chk #(.W(W)) u_chk (.*);

// File: tb/acc_logic_unit_tb.sv
module acc_logic_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = 4'd0;
    logic [7:0] opnd_i = 8'd0;
    logic       valid_i = 1'b0;
    logic [7:0] acc_o;
    logic       flag_s_o, flag_z_o, flag_ac_o, flag_p_o, flag_cy_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    int m_acc = 0;
    int m_s = 0, m_z = 0, m_ac = 0, m_p = 0, m_cy = 0;

    always #5 clk = ~clk;

    acc_logic_unit u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .opnd_i(opnd_i), .valid_i(valid_i),
        .acc_o(acc_o), .flag_s_o(flag_s_o), .flag_z_o(flag_z_o),
        .flag_ac_o(flag_ac_o), .flag_p_o(flag_p_o), .flag_cy_o(flag_cy_o),
        .done_o(done_o)
    );

    function automatic int ones(int v);
        int c = 0;
        for (int i = 0; i < 8; i++) if (((v >> i) % 2) == 1) c++;
        return c;
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R2";
            1, 2: return "R3";
            3: return "R4";
            4: return "R5";
            5, 6: return "R6";
            7, 8: return "R7";
            9, 10: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(string tag, int exp_done);
        int got_fl, exp_fl;
        got_fl = {27'd0, flag_s_o, flag_z_o, flag_ac_o, flag_p_o, flag_cy_o};
        exp_fl = m_s * 16 + m_z * 8 + m_ac * 4 + m_p * 2 + m_cy;
        n_chk++;
        if (int'(acc_o) != m_acc || got_fl != exp_fl || int'(done_o) != exp_done) begin
            n_bad++;
            $display("FAIL %s: acc=%02h flags(s z ac p cy)=%05b done=%0d expected acc=%02h flags=%05b done=%0d",
                     tag, acc_o, got_fl[4:0], done_o, m_acc[7:0], exp_fl[4:0], exp_done);
        end
    endtask

    task automatic set_szp(int r);
        m_s = (r >= 128) ? 1 : 0;
        m_z = (r == 0) ? 1 : 0;
        m_p = ((ones(r) % 2) == 0) ? 1 : 0;
    endtask

    // Issue one operation at a falling edge, then sample one cycle later.
    task automatic do_op(int op, int b);
        int a, nc, d;
        a = m_acc;
        op_i    = 4'(op);
        opnd_i  = 8'(b);
        valid_i = 1'b1;
        case (op)
            0: begin m_acc = a & b; set_szp(m_acc); m_ac = 1; m_cy = 0; end
            1: begin m_acc = a | b; set_szp(m_acc); m_ac = 0; m_cy = 0; end
            2: begin m_acc = a ^ b; set_szp(m_acc); m_ac = 0; m_cy = 0; end
            3: begin
                d = (a - b + 256) % 256;
                set_szp(d);
                m_z  = (a == b) ? 1 : 0;
                m_cy = (a < b) ? 1 : 0;
                m_ac = ((a % 16) < (b % 16)) ? 1 : 0;
            end
            4: m_acc = 255 - a;
            5: m_cy = 1 - m_cy;
            6: m_cy = 1;
            7: begin nc = a / 128; m_acc = (a * 2) % 256 + nc; m_cy = nc; end
            8: begin nc = a % 2; m_acc = a / 2 + nc * 128; m_cy = nc; end
            9: begin nc = a / 128; m_acc = (a * 2) % 256 + m_cy; m_cy = nc; end
            10: begin nc = a % 2; m_acc = a / 2 + m_cy * 128; m_cy = nc; end
            default: ;
        endcase
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        check(tag_of(op), 1);
    endtask

    task automatic load_acc(int v);
        do_op(0, 0);
        do_op(1, v);
    endtask

    task automatic load_cy(int c);
        do_op(6, 0);
        if (c == 0) do_op(5, 0);
    endtask

    task automatic idle_check(int op, int b);
        op_i   = 4'(op);
        opnd_i = 8'(b);
        @(posedge clk);
        @(negedge clk);
        check("R9", 0);
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 0);

        // directed examples
        load_acc(8'h1F); do_op(7, 0);
        load_acc(8'h0E); load_cy(1); do_op(9, 0);
        load_acc(8'h0E); load_cy(1); do_op(10, 0);
        load_acc(8'hAB); do_op(4, 0);
        load_acc(8'h20); do_op(3, 8'h10);
        load_acc(8'h10); do_op(3, 8'h10);
        load_acc(8'h10); do_op(3, 8'h30);

        // R9: no valid -> nothing moves, done stays low
        for (int k = 0; k < 6; k++) idle_check(k * 2, k * 41);

        // R2 R3 R4 sweep over all accumulator values
        for (int a = 0; a < 256; a++) begin
            for (int p = 0; p < 4; p++) begin
                for (int op = 0; op < 4; op++) begin
                    int b;
                    case (p)
                        0: b = 0;
                        1: b = 255;
                        2: b = a;
                        default: b = (a * 37 + 11) % 256;
                    endcase
                    load_acc(a);
                    do_op(op, b);
                end
            end
        end

        // R7 R8 rotates with both carry values; R5 complement with flags set
        for (int a = 0; a < 256; a++) begin
            for (int c = 0; c < 2; c++) begin
                for (int op = 7; op < 11; op++) begin
                    load_acc(a);
                    load_cy(c);
                    do_op(op, a);
                end
            end
            load_acc(a);
            do_op(3, (a + 77) % 256);
            do_op(4, 0);
            do_op(5, 0);
            do_op(5, 0);
        end

        // R10 unused codes with non-trivial flag state
        for (int op = 11; op < 16; op++) begin
            load_acc(op * 13);
            do_op(3, 200);
            do_op(op, 255 - op);
            idle_check(op, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule